// File: doc/BRIEF.md
# Exception Vector Dispatch Unit

This unit sits next to a simple in-order pipeline and converts exception events into a change of program flow. Each event carries a fixed exception number k. The handler entry point is the programmable table base plus four times k. The unit accepts several inputs: a level-sensitive external interrupt pin with an interrupt number from the system range, and request strobes from the execute stage for divide error, general protection fault, page fault, machine check and the system-call trap. It also takes the program counters of the current and the following instruction.

When an event is taken, the unit issues a one-cycle redirect to the handler address and records the exception number and class in a status register. It also stores a return address, which is picked by class. A fault stores the current instruction so that it re-executes. A trap or an interrupt stores the following instruction. An abort stores nothing and parks the unit in a halted state. Exception entry masks the interrupt pin. A one-cycle return strobe redirects to the stored address and unmasks it again.

Top module: `xcpt_dispatch`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `redir_valid` is 0, `irq_enable` is 1, `halted` is 0, `ret_addr` is 0, `stat_num` is 0, `stat_cls` is 0 and `tbl_base` equals the parameter RESET_BASE.
- R2: A cycle with `base_we` high loads `base_wdata` into `tbl_base` at the next edge. A dispatch in that same cycle still uses the previous base.
- R3: A divide error (number 0), protection fault (13) or page fault (14) makes `redir_valid` high for the following cycle, with `redir_pc` = base + 4·k, `stat_cls` = 0 (fault) and `ret_addr` = the `pc_cur` of the request cycle.
- R4: A system-call trap is number 128 with `stat_cls` = 1 (trap), and it stores the `pc_next` of the request cycle in `ret_addr`.
- R5: With `irq_enable` high, a high `irq_pin` dispatches number `irq_vec` (32 to 127) with `stat_cls` = 2 (interrupt) and stores `pc_next` in `ret_addr`.
- R6: Every taken event clears `irq_enable`. While it is clear, `irq_pin` causes no redirect and leaves the status unchanged.
- R7: A `ret_pulse` with no event pending redirects to `ret_addr` in the next cycle and sets `irq_enable`.
- R8: When several events are pending, the order is abort, then fault, then trap, then interrupt. Among faults the lowest number wins.
- R9: An event in the same cycle as `ret_pulse` is taken, and the return is dropped.
- R10: A machine check (number 18, `stat_cls` = 3, abort) redirects to its handler, sets `halted` and leaves `ret_addr` unchanged.
- R11: While `halted` is high, every event strobe, `irq_pin` and `ret_pulse` is ignored (no redirect, status and `irq_enable` held) until reset.
- R12: A fault requested together with `ev_fatal` is escalated: it dispatches with its own number but `stat_cls` = 3, sets `halted` and leaves `ret_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 1 | External interrupt request level |
| irq_vec | input | 8 | Exception number of the external interrupt |
| ev_div | input | 1 | Divide error request |
| ev_gpf | input | 1 | General protection fault request |
| ev_pgf | input | 1 | Page fault request |
| ev_mchk | input | 1 | Machine check request |
| ev_sysc | input | 1 | System-call trap request |
| ev_fatal | input | 1 | Marks the faults of this cycle as unrecoverable |
| pc_cur | input | ADDR_W | Address of the instruction raising the event |
| pc_next | input | ADDR_W | Address of the instruction that follows |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | ADDR_W | New table base |
| ret_pulse | input | 1 | Return-from-handler strobe |
| redir_valid | output | 1 | One-cycle redirect request |
| redir_pc | output | ADDR_W | Redirect target |
| ret_addr | output | ADDR_W | Stored return address |
| stat_num | output | 8 | Number of the last taken exception |
| stat_cls | output | 2 | Class of the last taken exception |
| irq_enable | output | 1 | Interrupt pin accepted when high |
| halted | output | 1 | Set by an abort, cleared only by reset |
| tbl_base | output | ADDR_W | Current table base |

## Verification
The properties assume that `irq_vec` lies in the system range 32 to 127 whenever `irq_pin` is high. They also assume the execute stage raises the fatal marker only together with a fault, and that `pc_next` is a real successor address. The stimulus follows these rules: every interrupt uses numbers such as 40 and 100, and the fatal marker appears only next to a page fault. Outside these assumptions, the priority and class checks would flag legal but meaningless traffic.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;

    localparam int XNUM_W = 8;
    localparam int NFAULT = 3;

    typedef enum logic [1:0] {
        XC_FAULT = 2'd0,
        XC_TRAP  = 2'd1,
        XC_INTR  = 2'd2,
        XC_ABORT = 2'd3
    } xclass_e;

    localparam logic [XNUM_W-1:0] XN_DIVIDE  = 8'd0;
    localparam logic [XNUM_W-1:0] XN_GPROT   = 8'd13;
    localparam logic [XNUM_W-1:0] XN_PAGE    = 8'd14;
    localparam logic [XNUM_W-1:0] XN_MCHECK  = 8'd18;
    localparam logic [XNUM_W-1:0] XN_SYSCALL = 8'h80;

    typedef struct packed {
        logic mchk;
        logic fatal;
        logic div;
        logic gpf;
        logic pgf;
        logic sysc;
    } xreq_t;

    typedef struct packed {
        logic              valid;
        logic [XNUM_W-1:0] num;
        xclass_e           cls;
    } xsel_t;

    // fault slot i -> exception number, slot 0 has the highest priority
    function automatic logic [XNUM_W-1:0] fault_num(input int slot);
        case (slot)
            0:       return XN_DIVIDE;
            1:       return XN_GPROT;
            default: return XN_PAGE;
        endcase
    endfunction

    // trap and interrupt resume after the instruction, a fault retries it
    function automatic logic resumes_next(input xclass_e c);
        return (c == XC_TRAP) || (c == XC_INTR);
    endfunction

endpackage

// File: rtl/xcpt_arbiter.sv
module xcpt_arbiter
    import xcpt_pkg::*;
(
    input  xreq_t              req,
    input  logic               irq_pin,
    input  logic [XNUM_W-1:0]  irq_vec,
    input  logic               irq_en,
    input  logic               halted,
    output xsel_t              sel
);

    logic [NFAULT-1:0]  fbits;
    logic               fany;
    logic [XNUM_W-1:0]  fnum;

    assign fbits = {req.pgf, req.gpf, req.div};
    assign fany  = |fbits;

    // lowest slot wins: scan from the top down, last hit stays
    always_comb begin
        fnum = fault_num(NFAULT - 1);
        for (int i = NFAULT - 1; i >= 0; i--) begin
            if (fbits[i]) begin
                fnum = fault_num(i);
            end
        end
    end

    always_comb begin
        sel.valid = 1'b0;
        sel.num   = '0;
        sel.cls   = XC_FAULT;
        if (!halted) begin
            if (req.mchk) begin
                sel.valid = 1'b1;
                sel.num   = XN_MCHECK;
                sel.cls   = XC_ABORT;
            end else if (fany) begin
                sel.valid = 1'b1;
                sel.num   = fnum;
                sel.cls   = req.fatal ? XC_ABORT : XC_FAULT;
            end else if (req.sysc) begin
                sel.valid = 1'b1;
                sel.num   = XN_SYSCALL;
                sel.cls   = XC_TRAP;
            end else if (irq_pin && irq_en) begin
                sel.valid = 1'b1;
                sel.num   = irq_vec;
                sel.cls   = XC_INTR;
            end
        end
    end

endmodule

// File: rtl/xcpt_vector.sv
module xcpt_vector
    import xcpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  base,
    input  xsel_t              sel,
    input  logic [ADDR_W-1:0]  pc_cur,
    input  logic [ADDR_W-1:0]  pc_next,
    output logic [ADDR_W-1:0]  target,
    output logic [ADDR_W-1:0]  resume
);

    localparam int ENTRY_SHIFT = 2;

    assign target = base + (ADDR_W'(sel.num) << ENTRY_SHIFT);
    assign resume = resumes_next(sel.cls) ? pc_next : pc_cur;

endmodule

// File: rtl/xcpt_ctx.sv
module xcpt_ctx
    import xcpt_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  xsel_t              sel,
    input  logic [ADDR_W-1:0]  target,
    input  logic [ADDR_W-1:0]  resume,
    input  logic               ret_pulse,
    input  logic               base_we,
    input  logic [ADDR_W-1:0]  base_wdata,
    output logic               redir_valid,
    output logic [ADDR_W-1:0]  redir_pc,
    output logic [ADDR_W-1:0]  ret_addr,
    output logic [XNUM_W-1:0]  stat_num,
    output xclass_e            stat_cls,
    output logic               irq_en,
    output logic               halted,
    output logic [ADDR_W-1:0]  base
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base        <= RESET_BASE;
            ret_addr    <= '0;
            stat_num    <= '0;
            stat_cls    <= XC_FAULT;
            irq_en      <= 1'b1;
            halted      <= 1'b0;
            redir_valid <= 1'b0;
            redir_pc    <= '0;
        end else begin
            redir_valid <= 1'b0;
            if (base_we) begin
                base <= base_wdata;
            end
            if (sel.valid && !halted) begin
                redir_valid <= 1'b1;
                redir_pc    <= target;
                stat_num    <= sel.num;
                stat_cls    <= sel.cls;
                irq_en      <= 1'b0;
                if (sel.cls == XC_ABORT) begin
                    halted <= 1'b1;
                end else begin
                    ret_addr <= resume;
                end
            end else if (ret_pulse && !halted) begin
                redir_valid <= 1'b1;
                redir_pc    <= ret_addr;
                irq_en      <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/xcpt_dispatch.sv
module xcpt_dispatch
    import xcpt_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_pin,
    input  logic [7:0]         irq_vec,
    input  logic               ev_div,
    input  logic               ev_gpf,
    input  logic               ev_pgf,
    input  logic               ev_mchk,
    input  logic               ev_sysc,
    input  logic               ev_fatal,
    input  logic [ADDR_W-1:0]  pc_cur,
    input  logic [ADDR_W-1:0]  pc_next,
    input  logic               base_we,
    input  logic [ADDR_W-1:0]  base_wdata,
    input  logic               ret_pulse,
    output logic               redir_valid,
    output logic [ADDR_W-1:0]  redir_pc,
    output logic [ADDR_W-1:0]  ret_addr,
    output logic [7:0]         stat_num,
    output logic [1:0]         stat_cls,
    output logic               irq_enable,
    output logic               halted,
    output logic [ADDR_W-1:0]  tbl_base
);

    xreq_t              req;
    xsel_t              sel;
    xclass_e            cls_q;
    logic [ADDR_W-1:0]  target;
    logic [ADDR_W-1:0]  resume;

    assign req = '{mchk: ev_mchk, fatal: ev_fatal, div: ev_div,
                   gpf: ev_gpf, pgf: ev_pgf, sysc: ev_sysc};

    xcpt_arbiter u_arb (
        .req     (req),
        .irq_pin (irq_pin),
        .irq_vec (irq_vec),
        .irq_en  (irq_enable),
        .halted  (halted),
        .sel     (sel)
    );

    xcpt_vector #(.ADDR_W(ADDR_W)) u_vec (
        .base    (tbl_base),
        .sel     (sel),
        .pc_cur  (pc_cur),
        .pc_next (pc_next),
        .target  (target),
        .resume  (resume)
    );

    xcpt_ctx #(.ADDR_W(ADDR_W), .RESET_BASE(RESET_BASE)) u_ctx (
        .clk         (clk),
        .rst         (rst),
        .sel         (sel),
        .target      (target),
        .resume      (resume),
        .ret_pulse   (ret_pulse),
        .base_we     (base_we),
        .base_wdata  (base_wdata),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .ret_addr    (ret_addr),
        .stat_num    (stat_num),
        .stat_cls    (cls_q),
        .irq_en      (irq_enable),
        .halted      (halted),
        .base        (tbl_base)
    );

    assign stat_cls = cls_q;

endmodule

// File: rtl/xcpt_dispatch_chk.sv
module xcpt_dispatch_chk #(
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_pin,
    input logic               ev_div,
    input logic               ev_gpf,
    input logic               ev_pgf,
    input logic               ev_mchk,
    input logic               ev_sysc,
    input logic               ev_fatal,
    input logic [ADDR_W-1:0]  pc_cur,
    input logic [ADDR_W-1:0]  pc_next,
    input logic               ret_pulse,
    input logic               redir_valid,
    input logic [ADDR_W-1:0]  redir_pc,
    input logic [ADDR_W-1:0]  ret_addr,
    input logic [7:0]         stat_num,
    input logic [1:0]         stat_cls,
    input logic               irq_enable,
    input logic               halted
);

    logic any_fault;
    logic any_sync;
    logic irq_live;

    assign any_fault = ev_div | ev_gpf | ev_pgf;
    assign any_sync  = any_fault | ev_mchk | ev_sysc;
    assign irq_live  = irq_pin & irq_enable;

    AST_FAULT_RETRIES: assert property (@(posedge clk) disable iff (rst)
        (!halted && any_fault && !ev_mchk && !ev_fatal)
        |=> (redir_valid && ret_addr == $past(pc_cur) && stat_cls == 2'd0)); // R3

    AST_TRAP_RESUMES_NEXT: assert property (@(posedge clk) disable iff (rst)
        (!halted && ev_sysc && !any_fault && !ev_mchk)
        |=> (ret_addr == $past(pc_next) && stat_num == 8'h80 && stat_cls == 2'd1)); // R4

    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (rst)
        (!halted && (any_sync || irq_live))
        |=> (redir_valid && !irq_enable)); // R6

    AST_RETURN_UNMASKS: assert property (@(posedge clk) disable iff (rst)
        (!halted && ret_pulse && !any_sync && !irq_live)
        |=> (redir_valid && irq_enable && redir_pc == $past(ret_addr))); // R7

    AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (rst)
        (!halted && ev_mchk)
        |=> (halted && stat_num == 8'd18 && $stable(ret_addr))); // R10

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !redir_valid && $stable(stat_num))); // R11

endmodule

bind xcpt_dispatch xcpt_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/xcpt_dispatch_bench.sv
module xcpt_dispatch_bench;

    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_pin = 1'b0;
    logic [7:0] irq_vec = 8'd0;
    logic ev_div = 1'b0, ev_gpf = 1'b0, ev_pgf = 1'b0;
    logic ev_mchk = 1'b0, ev_sysc = 1'b0, ev_fatal = 1'b0;
    logic [AW-1:0] pc_cur = '0, pc_next = '0;
    logic base_we = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic ret_pulse = 1'b0;
    logic redir_valid;
    logic [AW-1:0] redir_pc, ret_addr, tbl_base;
    logic [7:0] stat_num;
    logic [1:0] stat_cls;
    logic irq_enable, halted;

    always #10 clk = ~clk;

    xcpt_dispatch #(.ADDR_W(AW), .RESET_BASE('0)) u_xcpt_dispatch (
        .clk(clk), .rst(rst), .irq_pin(irq_pin), .irq_vec(irq_vec),
        .ev_div(ev_div), .ev_gpf(ev_gpf), .ev_pgf(ev_pgf), .ev_mchk(ev_mchk),
        .ev_sysc(ev_sysc), .ev_fatal(ev_fatal), .pc_cur(pc_cur), .pc_next(pc_next),
        .base_we(base_we), .base_wdata(base_wdata), .ret_pulse(ret_pulse),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .ret_addr(ret_addr),
        .stat_num(stat_num), .stat_cls(stat_cls), .irq_enable(irq_enable),
        .halted(halted), .tbl_base(tbl_base)
    );

    typedef struct {
        string         tag;
        logic          rv;
        logic [AW-1:0] rpc;
        logic [AW-1:0] epc;
        logic [7:0]    num;
        logic [1:0]    cls;
        logic          ien;
        logic          hlt;
        logic [AW-1:0] base;
    } exp_t;

    exp_t q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state, kept from the requirements
    logic [AW-1:0] m_base, m_epc;
    logic [7:0]    m_num;
    logic [1:0]    m_cls;
    logic          m_ien, m_hlt;

    function automatic exp_t snap(string tag, logic rv, logic [AW-1:0] rpc);
        exp_t e;
        e.tag = tag; e.rv = rv; e.rpc = rpc; e.epc = m_epc; e.num = m_num;
        e.cls = m_cls; e.ien = m_ien; e.hlt = m_hlt; e.base = m_base;
        return e;
    endfunction

    task automatic do_reset(string tag);
        @(negedge clk);
        rst = 1'b1;
        {irq_pin, ev_div, ev_gpf, ev_pgf, ev_mchk, ev_sysc, ev_fatal} = '0;
        {ret_pulse, base_we} = '0;
        @(posedge clk);
        @(posedge clk);
        m_base = '0; m_epc = '0; m_num = '0; m_cls = 2'd0; m_ien = 1'b1; m_hlt = 1'b0;
        q.push_back(snap(tag, 1'b0, '0));
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(string tag, bit mc, bit fatal, bit dv, bit gp, bit pf, bit sy,
                        bit irq, logic [7:0] inum, bit ret, bit bwe, logic [AW-1:0] bw,
                        logic [AW-1:0] pcc, logic [AW-1:0] pcn);
        logic take;
        logic [7:0] n;
        logic [1:0] c;
        logic [7:0] fnum;
        logic rv;
        logic [AW-1:0] rpc;
        @(negedge clk);
        ev_mchk = mc; ev_fatal = fatal; ev_div = dv; ev_gpf = gp; ev_pgf = pf;
        ev_sysc = sy; irq_pin = irq; irq_vec = inum; ret_pulse = ret;
        base_we = bwe; base_wdata = bw; pc_cur = pcc; pc_next = pcn;
        take = 1'b0; n = '0; c = 2'd0; rv = 1'b0; rpc = '0;
        fnum = dv ? 8'd0 : (gp ? 8'd13 : 8'd14);
        if (!m_hlt) begin
            if (mc)                     begin take = 1; n = 8'd18;  c = 2'd3; end
            else if ((dv|gp|pf) && fatal) begin take = 1; n = fnum; c = 2'd3; end
            else if (dv|gp|pf)          begin take = 1; n = fnum;   c = 2'd0; end
            else if (sy)                begin take = 1; n = 8'h80;  c = 2'd1; end
            else if (irq && m_ien)      begin take = 1; n = inum;   c = 2'd2; end
        end
        if (take) begin
            rv = 1'b1; rpc = m_base + (AW'(n) << 2);
            m_num = n; m_cls = c; m_ien = 1'b0;
            if (c == 2'd3) m_hlt = 1'b1;
            else m_epc = (c == 2'd0) ? pcc : pcn;
        end else if (ret && !m_hlt) begin
            rv = 1'b1; rpc = m_epc; m_ien = 1'b1;
        end
        if (bwe) m_base = bw;
        @(posedge clk);
        q.push_back(snap(tag, rv, rpc));
    endtask

    task automatic idle(string tag);
        step(tag, 0,0,0,0,0,0, 0,8'd0, 0, 0,'0, '0,'0);
    endtask

    task automatic ret_step(string tag);
        step(tag, 0,0,0,0,0,0, 0,8'd0, 1, 0,'0, '0,'0);
    endtask

    // monitor: compare one expected item per cycle, away from the clock edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                n_tests++;
                if (redir_valid !== e.rv || (e.rv && redir_pc !== e.rpc) ||
                    ret_addr !== e.epc || stat_num !== e.num || stat_cls !== e.cls ||
                    irq_enable !== e.ien || halted !== e.hlt || tbl_base !== e.base) begin
                    n_fail++;
                    $display("FAIL %s: actual rv=%0b pc=%h ret=%h num=%0d cls=%0d ien=%0b hlt=%0b base=%h expected rv=%0b pc=%h ret=%h num=%0d cls=%0d ien=%0b hlt=%0b base=%h",
                             e.tag, redir_valid, redir_pc, ret_addr, stat_num, stat_cls,
                             irq_enable, halted, tbl_base, e.rv, e.rpc, e.epc, e.num,
                             e.cls, e.ien, e.hlt, e.base);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        // R2: base write
        step("R2 base load", 0,0,0,0,0,0, 0,0, 0, 1,32'h1000, '0,'0);
        // R3: divide error retries the current instruction
        step("R3 divide fault", 0,0,1,0,0,0, 0,0, 0, 0,'0, 32'h100,32'h104);
        // R6: interrupt masked inside the handler
        step("R6 masked irq ignored", 0,0,0,0,0,0, 1,8'd40, 0, 0,'0, 32'h200,32'h204);
        ret_step("R7 return to fault site");
        // R4 plus R2: trap uses the old base while a new one is written
        step("R4 R2 syscall with base write", 0,0,0,0,0,1, 0,0, 0, 1,32'h2000, 32'h300,32'h302);
        ret_step("R7 return after trap");
        // R5: interrupt from the system range
        step("R5 irq 40", 0,0,0,0,0,0, 1,8'd40, 0, 0,'0, 32'h400,32'h404);
        ret_step("R7 return after irq");
        // R8: fault beats trap and interrupt, lowest fault number wins
        step("R8 gp vs pf vs trap vs irq", 0,0,0,1,1,1, 1,8'd100, 0, 0,'0, 32'h500,32'h508);
        // R9: event beats a return in the same cycle
        step("R9 page fault with return", 0,0,0,0,1,0, 0,0, 1, 0,'0, 32'h600,32'h604);
        ret_step("R7 return after pf");
        // R8: trap beats interrupt
        step("R8 trap vs irq", 0,0,0,0,0,1, 1,8'd100, 0, 0,'0, 32'h700,32'h704);
        ret_step("R7 return after trap 2");
        idle("R6 idle after return");
        // R10: machine check outranks a divide error and halts
        step("R10 machine check", 1,0,1,0,0,0, 0,0, 0, 0,'0, 32'h800,32'h804);
        // R11: everything ignored while halted
        step("R11 fault while halted", 0,0,1,0,0,1, 1,8'd50, 0, 0,'0, 32'h900,32'h904);
        ret_step("R11 return while halted");
        idle("R11 idle while halted");
        do_reset("R1 reset after halt");
        // R12: unrecoverable page fault escalates
        step("R12 fatal page fault", 0,1,0,0,1,0, 0,0, 0, 0,'0, 32'hA00,32'hA04);
        step("R11 irq after escalation", 0,0,0,0,0,0, 1,8'd60, 1, 0,'0, '0,'0);
        idle("R12 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule